// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block generates the strobe waveform for one access on an external parallel bus. Each access begins with an address phase in two halves, each marked by a one-clock latch strobe. A programmable latency wait follows, and then an active-low read or write strobe is held for a programmable number of clocks. A burst of several words keeps the single address phase and repeats only the strobe. A fixed two-clock release gap separates consecutive strobes.

The bus is split into two address domains. Each domain keeps its own 8-bit latency value and 8-bit strobe-width value in a small timing bank, which a configuration write port loads. A start request selects the domain, the direction and the word count. The sequencer copies the selected timing values at that moment, so a configuration write during an access does not change that access. For reads, a capture pulse marks the clock on which the external word can be sampled. A done pulse marks the return to idle.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, both strobes are high (1) and `ale_hi`, `ale_lo`, `cap_pulse` and `done` are low. Both domains hold latency 64 (0x40) and strobe width 18 (0x12).
- R2: The clock after a start is accepted, `ale_hi` is high for exactly one clock. In the next clock `ale_lo` is high for exactly one clock. The two are never high together.
- R3: The first strobe goes low L clocks after the `ale_lo` clock, where L is the domain's latency value (0 to 255). With L = 0 it goes low in the clock right after `ale_lo`.
- R4: Each strobe stays low for P clocks, where P is the domain's width value. A width of 0 gives a one-clock strobe.
- R5: With `wr_mode` = 1 the strobe appears on `wr_n`. With `wr_mode` = 0 it appears on `rd_n`. The other strobe stays high, and both are never low together.
- R6: For reads, `cap_pulse` is high only on the last low clock of each `rd_n` strobe. For writes it never rises.
- R7: A transfer of N words (`burst_len`, 0 treated as 1) produces one address phase and N strobes. The strobes are separated by exactly 2 clocks with both strobes high.
- R8: `dom_sel` picks the domain whose timing values are used. A cycle with `cfg_we` = 1 loads `cfg_lat` and `cfg_pw` into the domain given by `cfg_dom`. The new values take effect from the next accepted start.
- R9: A start is accepted only while the sequencer is idle, and a start during a transfer has no effect on the waveform. The timing values are copied at acceptance, so a configuration write during a transfer leaves that transfer unchanged.
- R10: `done` is high for exactly one clock: the first idle clock after the last strobe. A start presented in that clock is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to begin a transfer (accepted only when idle) |
| dom_sel | input | DOM_W | Domain for the requested transfer |
| wr_mode | input | 1 | 1 = write transfer, 0 = read transfer |
| burst_len | input | WORDS_W | Number of words in the transfer, 0 means 1 |
| cfg_we | input | 1 | Load timing values into a domain |
| cfg_dom | input | DOM_W | Domain written by `cfg_we` |
| cfg_lat | input | CNT_W | Latency value to load |
| cfg_pw | input | CNT_W | Strobe width value to load |
| ale_hi | output | 1 | Upper address half latch strobe |
| ale_lo | output | 1 | Lower address half latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cap_pulse | output | 1 | Read data sample point |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench compares every output on every clock of a transfer against a cycle model built from L, P, N and the direction. Reads and writes show which strobe is chosen and whether capture pulses appear. Default timing runs separate the reset values from loaded values. L = 0 with P = 0 shows the clamping and immediate-strobe rules, and L = P = 255 exercises the counter limit. Multi-word and zero-count bursts show the gap and the word counting. A start during a transfer, a configuration write during a transfer, and a start on the done clock separate the rules about when requests and timing changes are taken.

// File: rtl/bcs_pkg.sv
// Package: shared types and constants of the bus cycle sequencer.
// Assumes: included first in compile order.
package bcs_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR_H = 3'd1,
        ST_ADDR_L = 3'd2,
        ST_LAT    = 3'd3,
        ST_STROBE = 3'd4,
        ST_GAP    = 3'd5
    } seq_state_t;

    // Clocks the strobes stay high between burst words
    localparam int GAP_CYC = 2;

endpackage

// File: rtl/bcs_timing_bank.sv
// Module: bcs_timing_bank
// Holds one latency and one strobe-width value per domain.
// A config write loads the addressed domain in one clock.
// Assumes: cfg_dom is below NUM_DOM, and reset is synchronous active-low.
module bcs_timing_bank #(
    parameter int NUM_DOM = 2,
    parameter int CNT_W   = 8,
    parameter int DOM_W   = 1,
    parameter logic [CNT_W-1:0] LAT_RST = 8'h40,
    parameter logic [CNT_W-1:0] PW_RST  = 8'h12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [DOM_W-1:0]               cfg_dom,
    input  logic [CNT_W-1:0]               cfg_lat,
    input  logic [CNT_W-1:0]               cfg_pw,
    output logic [NUM_DOM-1:0][CNT_W-1:0]  lat_all,
    output logic [NUM_DOM-1:0][CNT_W-1:0]  pw_all
);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        // Per-domain timing register: reset default, or load on a matching config write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_all[d] <= LAT_RST;
                pw_all[d]  <= PW_RST;
            end else if (cfg_we && (cfg_dom == DOM_W'(d))) begin
                lat_all[d] <= cfg_lat;
                pw_all[d]  <= cfg_pw;
            end
        end
    end

endmodule

// File: rtl/bcs_fsm.sv
// Module: bcs_fsm
// Phase sequencer: address halves, latency wait, strobe, and the gap
// between burst words. The output strobes are decoded from the registered phase.
// Assumes: sel_lat and sel_pw hold the timing values of the requested domain
// in the start cycle. They are copied there and not read again.
module bcs_fsm
    import bcs_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int WORDS_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               wr_mode,
    input  logic [WORDS_W-1:0] burst_len,
    input  logic [CNT_W-1:0]   sel_lat,
    input  logic [CNT_W-1:0]   sel_pw,
    output logic               ale_hi,
    output logic               ale_lo,
    output logic               rd_n,
    output logic               wr_n,
    output logic               cap_pulse,
    output logic               done
);

    localparam logic [CNT_W-1:0]   CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0]   GAP_LAST = CNT_W'(GAP_CYC);
    localparam logic [WORDS_W-1:0] WORD_ONE = WORDS_W'(1);

    seq_state_t         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   lat_q;
    logic [CNT_W-1:0]   pw_q;
    logic [WORDS_W-1:0] left_q;
    logic               wr_q;
    logic               done_q;
    logic               strobe_end;

    // Last clock of the current strobe
    always_comb strobe_end = (state_q == ST_STROBE) && (cnt_q == pw_q);

    // Phase register, shared phase counter and copy of the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lat_q   <= '0;
            pw_q    <= CNT_ONE;
            left_q  <= WORD_ONE;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        lat_q   <= sel_lat;
                        pw_q    <= (sel_pw == '0) ? CNT_ONE : sel_pw;
                        left_q  <= (burst_len == '0) ? WORD_ONE : burst_len;
                        wr_q    <= wr_mode;
                        state_q <= ST_ADDR_H;
                    end
                end
                ST_ADDR_H: state_q <= ST_ADDR_L;
                ST_ADDR_L: begin
                    cnt_q   <= CNT_ONE;
                    state_q <= (lat_q == '0) ? ST_STROBE : ST_LAT;
                end
                ST_LAT: begin
                    if (cnt_q == lat_q) begin
                        cnt_q   <= CNT_ONE;
                        state_q <= ST_STROBE;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                ST_STROBE: begin
                    if (strobe_end) begin
                        cnt_q <= CNT_ONE;
                        if (left_q == WORD_ONE) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            left_q  <= left_q - WORD_ONE;
                            state_q <= ST_GAP;
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                ST_GAP: begin
                    if (cnt_q == GAP_LAST) begin
                        cnt_q   <= CNT_ONE;
                        state_q <= ST_STROBE;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the registered phase
    always_comb begin
        ale_hi    = (state_q == ST_ADDR_H);
        ale_lo    = (state_q == ST_ADDR_L);
        rd_n      = !((state_q == ST_STROBE) && !wr_q);
        wr_n      = !((state_q == ST_STROBE) && wr_q);
        cap_pulse = strobe_end && !wr_q;
        done      = done_q;
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R2
    addr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_hi |=> (ale_lo && !ale_hi));

    // R6
    cap_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |-> (!rd_n && wr_n));

    // R6
    cap_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> rd_n);

    // R10
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!rd_n || !wr_n));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && start_req) |=> !ale_hi);

endmodule

// File: rtl/bus_cycle_seq.sv
// Module: bus_cycle_seq (top)
// Per-domain timing bank plus the phase sequencer. The timing values of the
// requested domain are routed to the sequencer, which copies them on a start.
// Assumes: dom_sel and cfg_dom are below NUM_DOM. Synchronous active-low reset.
module bus_cycle_seq #(
    parameter int NUM_DOM = 2,
    parameter int CNT_W   = 8,
    parameter int WORDS_W = 4,
    parameter int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic [DOM_W-1:0]   dom_sel,
    input  logic               wr_mode,
    input  logic [WORDS_W-1:0] burst_len,
    input  logic               cfg_we,
    input  logic [DOM_W-1:0]   cfg_dom,
    input  logic [CNT_W-1:0]   cfg_lat,
    input  logic [CNT_W-1:0]   cfg_pw,
    output logic               ale_hi,
    output logic               ale_lo,
    output logic               rd_n,
    output logic               wr_n,
    output logic               cap_pulse,
    output logic               done
);

    localparam logic [CNT_W-1:0] LAT_DEF = CNT_W'(8'h40);
    localparam logic [CNT_W-1:0] PW_DEF  = CNT_W'(8'h12);

    logic [NUM_DOM-1:0][CNT_W-1:0] lat_all;
    logic [NUM_DOM-1:0][CNT_W-1:0] pw_all;
    logic [CNT_W-1:0]              sel_lat;
    logic [CNT_W-1:0]              sel_pw;

    bcs_timing_bank #(
        .NUM_DOM (NUM_DOM),
        .CNT_W   (CNT_W),
        .DOM_W   (DOM_W),
        .LAT_RST (LAT_DEF),
        .PW_RST  (PW_DEF)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_dom (cfg_dom),
        .cfg_lat (cfg_lat),
        .cfg_pw  (cfg_pw),
        .lat_all (lat_all),
        .pw_all  (pw_all)
    );

    // Route the requested domain's timing values to the sequencer
    always_comb begin
        sel_lat = lat_all[dom_sel];
        sel_pw  = pw_all[dom_sel];
    end

    bcs_fsm #(
        .CNT_W   (CNT_W),
        .WORDS_W (WORDS_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .wr_mode   (wr_mode),
        .burst_len (burst_len),
        .sel_lat   (sel_lat),
        .sel_pw    (sel_pw),
        .ale_hi    (ale_hi),
        .ale_lo    (ale_lo),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .cap_pulse (cap_pulse),
        .done      (done)
    );

endmodule

// File: tb/tb_bus_cycle_seq.sv
// Directed bench: each task runs one scenario. Every output is compared
// on every clock against a cycle model derived from the requirements.
module tb_bus_cycle_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic [0:0] dom_sel = '0;
    logic       wr_mode = 1'b0;
    logic [3:0] burst_len = '0;
    logic       cfg_we = 1'b0;
    logic [0:0] cfg_dom = '0;
    logic [7:0] cfg_lat = '0;
    logic [7:0] cfg_pw = '0;
    logic       ale_hi, ale_lo, rd_n, wr_n, cap_pulse, done;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    bus_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .dom_sel(dom_sel),
        .wr_mode(wr_mode), .burst_len(burst_len), .cfg_we(cfg_we),
        .cfg_dom(cfg_dom), .cfg_lat(cfg_lat), .cfg_pw(cfg_pw),
        .ale_hi(ale_hi), .ale_lo(ale_lo), .rd_n(rd_n), .wr_n(wr_n),
        .cap_pulse(cap_pulse), .done(done)
    );

    function automatic logic [5:0] outs();
        return {ale_hi, ale_lo, rd_n, wr_n, cap_pulse, done};
    endfunction

    // Expected {ale_hi, ale_lo, rd_n, wr_n, cap, done} at clock i after acceptance
    function automatic logic [5:0] exp_vec(int i, int lat, int pe, int ne, logic w);
        logic hi = 0, lo = 0, rdn = 1, wrn = 1, cp = 0, dn = 0;
        int t, per, last;
        if (i == 1) hi = 1;
        else if (i == 2) lo = 1;
        else begin
            t = i - 3 - lat;
            per = pe + 2;
            last = (ne - 1) * per + pe;
            if (t >= 0) begin
                if (t == last) dn = 1;
                else if (t < last && (t % per) < pe) begin
                    if (w) wrn = 0; else rdn = 0;
                    if (!w && (t % per) == pe - 1) cp = 1;
                end
            end
        end
        return {hi, lo, rdn, wrn, cp, dn};
    endfunction

    task automatic check(input bit ok, input string req, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic d, input int lat, input int pw);
        @(negedge clk);
        cfg_we = 1; cfg_dom = d; cfg_lat = 8'(lat); cfg_pw = 8'(pw);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // mode 0: plain, 1: foreign start mid-transfer, 2: config write mid-transfer
    task automatic run_xfer(input string req, input logic d, input logic w, input int n,
                            input int lat, input int pw, input int mode);
        int ne = (n == 0) ? 1 : n;
        int pe = (pw == 0) ? 1 : pw;
        int total = 3 + lat + (ne - 1) * (pe + 2) + pe + 2;
        int bad = 0;
        logic [5:0] g, e, fg, fe;
        fg = '0; fe = '0;
        @(negedge clk);
        dom_sel = d; wr_mode = w; burst_len = 4'(n); start_req = 1;
        for (int i = 1; i <= total; i++) begin
            @(negedge clk);
            g = outs();
            e = exp_vec(i, lat, pe, ne, w);
            if (g !== e) begin
                if (bad == 0) begin fg = g; fe = e; end
                bad++;
            end
            if (i == 1) start_req = 0;
            if (mode == 1 && i == 5) begin start_req = 1; dom_sel = ~d; wr_mode = ~w; end
            if (mode == 1 && i == 6) begin start_req = 0; dom_sel = d; wr_mode = w; end
            if (mode == 2 && i == 4) begin cfg_we = 1; cfg_dom = d; cfg_lat = 8'd9; cfg_pw = 8'd5; end
            if (mode == 2 && i == 5) cfg_we = 0;
        end
        check(bad == 0, req, fg, fe);
    endtask

    // R1: outputs while and right after reset
    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check(outs() == 6'b001100, "R1 reset outputs", outs(), 6'b001100);
        rst_n = 1;
        @(negedge clk);
        check(outs() == 6'b001100, "R1 idle after reset", outs(), 6'b001100);
    endtask

    // R10: start presented on the done clock is accepted
    task automatic t_back_to_back();
        int k = 0;
        @(negedge clk);
        dom_sel = 1; wr_mode = 1; burst_len = 1; start_req = 1;
        @(negedge clk);
        start_req = 0;
        while (!done && k < 400) begin @(negedge clk); k++; end
        dom_sel = 0; wr_mode = 0; start_req = 1;
        @(negedge clk);
        start_req = 0;
        check(outs() == 6'b101100, "R10 start on done clock accepted", outs(), 6'b101100);
        k = 0;
        while (!done && k < 400) begin @(negedge clk); k++; end
        @(negedge clk);
        check(outs() == 6'b001100, "R10 done single clock", outs(), 6'b001100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        run_xfer("R1 R3 R4 R6 default timing dom0 read", 0, 0, 1, 64, 18, 0);
        run_xfer("R1 R5 default timing dom1 write", 1, 1, 1, 64, 18, 0);
        cfg_write(0, 3, 2);
        cfg_write(1, 0, 0);
        run_xfer("R7 R8 R2 dom0 read burst of 3", 0, 0, 3, 3, 2, 0);
        run_xfer("R3 R4 R7 dom1 write zero latency zero width burst 2", 1, 1, 2, 0, 0, 0);
        run_xfer("R7 R6 dom1 read zero burst count", 1, 0, 0, 0, 0, 0);
        run_xfer("R9 start during transfer ignored", 0, 0, 2, 3, 2, 1);
        run_xfer("R9 config write during transfer ignored", 0, 1, 1, 3, 2, 2);
        run_xfer("R8 new dom0 values after write", 0, 0, 2, 9, 5, 0);
        run_xfer("R8 dom1 untouched by dom0 write", 1, 0, 1, 0, 0, 0);
        cfg_write(1, 255, 255);
        run_xfer("R3 R4 maximum latency and width read", 1, 0, 2, 255, 255, 0);
        run_xfer("R5 R6 maximum timing write", 1, 1, 1, 255, 255, 0);
        cfg_write(1, 0, 1);
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule